// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the interrupt sources of a tiled graphics engine and presents them to software through a small word-addressed register bus. Two sources feed it. The first is a frame-completion pulse. The second is an out-of-memory level that the tiling binner raises when its spill memory runs out. Each source owns one bit in a pending-status register, and software clears a bit by writing a 1 to it. A frame-completion bit stays cleared once acknowledged. The out-of-memory bit comes straight back for as long as its cause is still present.

Software never writes the enable mask directly. A write to the enable-set register turns on the bits written as 1, and a write to the enable-clear register turns off the bits written as 1. Both addresses read back the same current mask. One interrupt line goes high whenever some pending bit is also enabled.

To resolve an out-of-memory condition, software places a new spill pool by writing its base address and then its size. The size write produces a one-cycle refill strobe towards the binner. The binner then drops its out-of-memory level, and only after that does an acknowledge of that status bit take effect.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: Reset (rst_n low) zeroes the pending status, the enable mask, the pool base and the pool size, and holds irq and pool_refill low.
- R2: The status register sits at address 0x0, with bit 0 for frame completion and bit 1 for out-of-memory. A write there clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A one-cycle pulse on frame_done sets status bit 0 at the next clock edge, and the bit stays set until it is cleared. If the pulse and a clearing write land in the same cycle, the bit stays set.
- R4: While oom_level is high, status bit 1 is set and remains set after a clearing write. Once oom_level is low, a clearing write leaves the bit at 0.
- R5: Writing address 0x1 (enable-set) sets each enable bit written as 1. Bits written as 0 leave their enable bit unchanged.
- R6: Writing address 0x2 (enable-clear) clears each enable bit written as 1. Bits written as 0 leave their enable bit unchanged.
- R7: Reads of address 0x1 and of address 0x2 both return the current enable mask in bits 1:0, with the upper bits zero.
- R8: irq is high exactly when some status bit and the matching enable bit are both 1. It follows the registered status and mask combinationally.
- R9: Address 0x3 holds the pool base and address 0x4 holds the pool size. Both read back what was written and drive pool_base and pool_size. A write to 0x4 makes pool_refill high for the following cycle.
- R10: Reads of any address above 0x4 return zero, and writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | DATA_W | Read data, zero when no read is in progress |
| frame_done | input | 1 | Frame-completion event pulse |
| oom_level | input | 1 | Binner out-of-memory condition (level) |
| irq | output | 1 | Combined interrupt request |
| pool_base | output | DATA_W | Current spill pool base address |
| pool_size | output | DATA_W | Current spill pool size |
| pool_refill | output | 1 | One-cycle strobe that follows a pool size write |

## Verification
The status logic is tried with several input patterns.
- A lone frame pulse shows that the event latches and that the event bit ignores a zero write.
- A frame pulse that meets its own clearing write in the same cycle separates event priority from clear priority.
- A held out-of-memory level, acknowledged once before the refill and once after, separates a level source from an edge source.

The enable registers are tried with masks that hold a zero beside a one. This shows that the zero bits are left alone, and reading both enable addresses after each change shows they share one mask. A write to an unmapped address followed by readback of every real register tells a proper decode apart from address aliasing.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;

  // Source bit positions inside status and enable
  localparam int unsigned SRC_FRAME = 0;
  localparam int unsigned SRC_OOM   = 1;

  // Register word addresses; order is the software-visible map
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [2:0] {
    REG_STATUS    = 3'd0,
    REG_EN_SET    = 3'd1,
    REG_EN_CLR    = 3'd2,
    REG_POOL_BASE = 3'd3,
    REG_POOL_SIZE = 3'd4,
    REG_NONE      = 3'd7
  } reg_sel_e;

  // Pending bit: a new hit outranks an acknowledge
  function automatic logic pend_next(input logic cur, input logic hit, input logic ack);
    return hit | (cur & ~ack);
  endfunction

  // Enable bit: set mask then clear mask (only one is active per cycle)
  function automatic logic en_next(input logic cur, input logic set_b, input logic clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

endpackage

// File: rtl/gfx_irq_regdec.sv
module gfx_irq_regdec
  import gfx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  output reg_sel_e            sel,
  output logic [NUM_REGS-1:0] wr_hit
);

  always_comb begin
    sel = REG_NONE;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr == ADDR_W'(k)) sel = reg_sel_e'(3'(k));
    end
  end

  always_comb begin
    wr_hit = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (wr && (sel == reg_sel_e'(3'(k)))) wr_hit[k] = 1'b1;
    end
  end

endmodule

// File: rtl/gfx_irq_status.sv
module gfx_irq_status
  import gfx_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  // 1 = level source (status follows the input), 0 = event source (rising edge)
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 2'b10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] src_hit,
  output logic [NUM_SRC-1:0] status_q
);

  logic [NUM_SRC-1:0] status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign src_hit[i] = src_in[i];
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in[i];
      end
      assign src_hit[i] = src_in[i] & ~prev_q;
    end
    assign status_d[i] = pend_next(status_q[i], src_hit[i], ack_wr & ack_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/gfx_irq_enable.sv
module gfx_irq_enable
  import gfx_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_wr,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] en_q
);

  logic [NUM_SRC-1:0] en_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    assign en_d[i] = en_next(en_q[i], set_wr & mask[i], clr_wr & mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              size_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] size_q,
  output logic              refill_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      size_q   <= '0;
      refill_q <= 1'b0;
    end else begin
      if (base_wr) base_q <= wdata;
      if (size_wr) size_q <= wdata;
      refill_q <= size_wr;
    end
  end

endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_done,
  input  logic              oom_level,
  output logic              irq,
  output logic [DATA_W-1:0] pool_base,
  output logic [DATA_W-1:0] pool_size,
  output logic              pool_refill
);

  localparam logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'(1) << SRC_OOM;

  reg_sel_e            sel;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_SRC-1:0]  src_in;
  logic [NUM_SRC-1:0]  src_hit;
  logic [NUM_SRC-1:0]  status_q;
  logic [NUM_SRC-1:0]  en_q;
  logic [NUM_SRC-1:0]  wmask;

  always_comb begin
    src_in            = '0;
    src_in[SRC_FRAME] = frame_done;
    src_in[SRC_OOM]   = oom_level;
  end

  assign wmask = bus_wdata[NUM_SRC-1:0];

  gfx_irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .sel    (sel),
    .wr_hit (wr_hit)
  );

  gfx_irq_status #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .ack_wr   (wr_hit[REG_STATUS]),
    .ack_mask (wmask),
    .src_hit  (src_hit),
    .status_q (status_q)
  );

  gfx_irq_enable #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_hit[REG_EN_SET]),
    .clr_wr (wr_hit[REG_EN_CLR]),
    .mask   (wmask),
    .en_q   (en_q)
  );

  gfx_irq_pool #(.DATA_W(DATA_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_wr  (wr_hit[REG_POOL_BASE]),
    .size_wr  (wr_hit[REG_POOL_SIZE]),
    .wdata    (bus_wdata),
    .base_q   (pool_base),
    .size_q   (pool_size),
    .refill_q (pool_refill)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        REG_STATUS:              bus_rdata = DATA_W'(status_q);
        REG_EN_SET, REG_EN_CLR:  bus_rdata = DATA_W'(en_q);
        REG_POOL_BASE:           bus_rdata = pool_base;
        REG_POOL_SIZE:           bus_rdata = pool_size;
        default:                 bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(status_q & en_q);

endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] src_hit,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               irq,
  input logic [DATA_W-1:0]  pool_base,
  input logic [DATA_W-1:0]  pool_size,
  input logic               pool_refill
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && status_q == '0 && !irq && !pool_refill));

  // R3
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_hit[0] |=> status_q[0]);

  // R4
  oom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_in[1] |=> status_q[1]);

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0]) |=> en_q[0]);

  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[0]) |=> !en_q[0]);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0 && en_q != '0));

  // R9
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=> pool_refill);

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > ADDR_W'(4)) |=>
      ($stable(en_q) && $stable(pool_base) && $stable(pool_size)));

endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .src_in      (src_in),
  .src_hit     (src_hit),
  .status_q    (status_q),
  .en_q        (en_q),
  .irq         (irq),
  .pool_base   (pool_base),
  .pool_size   (pool_size),
  .pool_refill (pool_refill)
);

// File: tb/gfx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_tb;

  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          frame_done = 1'b0;
  logic          oom_level = 1'b0;
  logic          irq;
  logic [DW-1:0] pool_base;
  logic [DW-1:0] pool_size;
  logic          pool_refill;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  gfx_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_SRC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .oom_level(oom_level), .irq(irq),
    .pool_base(pool_base), .pool_size(pool_size), .pool_refill(pool_refill)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb_q.size() == 0) check(1, 0, "scoreboard underflow");
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_rdata, e.val, e.tag);
      end
    end
  end

  task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic frame_pulse();
    @(posedge clk); #1 frame_done = 1'b1;
    @(posedge clk); #1 frame_done = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check(irq, 0, "R1 irq");
    check(pool_refill, 0, "R1 refill");
    reg_rd(0, 0, "R1 status");
    reg_rd(1, 0, "R1 enable");
    reg_rd(3, 0, "R1 base");
    reg_rd(4, 0, "R1 size");

    // R3 frame event latches while disabled, R8 no irq
    frame_pulse();
    reg_rd(0, 32'h1, "R3 frame latched");
    check(irq, 0, "R8 disabled pending");

    // R5 set with a zero bit beside, R7 both views
    reg_wr(1, 32'h1);
    check(irq, 1, "R8 enabled pending");
    reg_rd(1, 32'h1, "R5 enable set");
    reg_rd(2, 32'h1, "R7 enable via clr addr");

    // R2 zero bits untouched, one bit clears
    reg_wr(0, 32'h2);
    reg_rd(0, 32'h1, "R2 zero write keeps");
    reg_wr(0, 32'h1);
    reg_rd(0, 32'h0, "R2 one write clears");
    check(irq, 0, "R8 after clear");

    // R3 event and clear in the same cycle
    @(posedge clk); #1;
    frame_done = 1'b1; bus_addr = 0; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(posedge clk); #1;
    frame_done = 1'b0; bus_wr = 1'b0;
    reg_rd(0, 32'h1, "R3 event beats clear");
    reg_wr(0, 32'h1);
    reg_rd(0, 32'h0, "R3 stays cleared");

    // R4 level source
    @(posedge clk); #1 oom_level = 1'b1;
    reg_wr(1, 32'h2);
    reg_rd(1, 32'h3, "R5 second bit set");
    reg_rd(0, 32'h2, "R4 oom pending");
    check(irq, 1, "R8 oom irq");
    reg_wr(0, 32'h2);
    reg_rd(0, 32'h2, "R4 persists after clear");

    // R6 clear with a zero bit beside
    reg_wr(2, 32'h1);
    reg_rd(1, 32'h2, "R6 clear one bit");
    check(irq, 1, "R8 oom still enabled");
    reg_wr(2, 32'h2);
    reg_rd(2, 32'h0, "R6 clear second bit");
    check(irq, 0, "R8 all disabled");

    // R9 pool registers and refill strobe
    reg_wr(3, 32'hABCD_0000);
    check(pool_refill, 0, "R9 no refill on base");
    reg_wr(4, 32'h0004_0000);
    check(pool_refill, 1, "R9 refill strobe");
    @(posedge clk); #1;
    check(pool_refill, 0, "R9 refill single cycle");
    oom_level = 1'b0;
    reg_rd(3, 32'hABCD_0000, "R9 base readback");
    reg_rd(4, 32'h0004_0000, "R9 size readback");
    check(pool_base, 32'hABCD_0000, "R9 base port");
    reg_wr(0, 32'h2);
    reg_rd(0, 32'h0, "R4 cleared after cause gone");

    // R10 unmapped
    reg_wr(1, 32'h1);
    reg_wr(7, 32'hFFFF_FFFF);
    reg_wr(15, 32'hFFFF_FFFF);
    reg_rd(7, 32'h0, "R10 unmapped read");
    reg_rd(1, 32'h1, "R10 enable untouched");
    reg_rd(3, 32'hABCD_0000, "R10 base untouched");
    reg_rd(4, 32'h0004_0000, "R10 size untouched");
    reg_rd(0, 32'h0, "R10 status untouched");

    @(posedge clk); #1;
    if (sb_q.size() != 0) check(DW'(sb_q.size()), 0, "scoreboard drained");
    summary();
  end

endmodule